// File: doc/BRIEF.md
# MESI Snooping Coherence Controller

This block keeps one private write-back cache coherent with its peers on a shared bus. It holds a direct-mapped array of line tags, each line carrying one of four states: Invalid, Shared, Exclusive (clean, sole copy) or Modified (dirty, sole copy). It serves one processor access at a time and classifies it as a hit or a miss. When it needs the bus it raises a request (read, read-for-ownership, or write-back) and waits for a grant. In parallel it watches the transactions of the other caches, answering each one in the same cycle on a wired-OR shared line and a flush line.

The clean-exclusive state is chosen at fill time from the shared line. When no other cache holds the line, a later write needs no bus transaction, so a read-modify-write of private data costs one bus transaction instead of two. Data storage, memory timing and arbitration are outside the block. The bus never grants this controller in a cycle that carries a snooped transaction from another cache.

Top module: `coh_mesi_ctrl`

## Requirements
- R1: After reset every line is Invalid. The controller is idle and ready, issues no bus request and gives no response. A snoop to any address drives neither `snp_shared_out` nor `snp_flush_out`.
- R2: A read hit in Exclusive, Shared or Modified responds one cycle after acceptance with `cpu_resp_hit`=1. It raises no bus request and leaves the line state unchanged.
- R3: A read miss requests command code 1 (read) for the requested address. On the grant edge the line is installed as Exclusive if `bus_shared_in` is low and as Shared if it is high. The response, with `cpu_resp_hit`=0, comes one cycle after the grant.
- R4: A write hit in Exclusive moves the line to Modified without a bus request. A write hit in Modified stays local. Both respond one cycle after acceptance with `cpu_resp_hit`=1.
- R5: A write hit in Shared requests command code 2 (read-for-ownership) and holds that request, with the controller busy, until granted. The line then becomes Modified, and the response with `cpu_resp_hit`=1 follows one cycle after the grant.
- R6: A write miss requests command code 2 for the requested address and installs the line as Modified. The response with `cpu_resp_hit`=0 comes one cycle after the grant.
- R7: A miss whose victim line is Modified first requests command code 3 (write-back) at the victim's address (stored tag above the index bits), and only then the fill. A victim in Exclusive or Shared is dropped silently and the fill request comes first.
- R8: A snooped read (code 1) that matches a valid line raises `snp_shared_out` in the same cycle. If the line is Modified it also raises `snp_flush_out`. Modified and Exclusive lines become Shared, and a Shared line stays Shared.
- R9: A snooped read-for-ownership (code 2) that matches a valid line invalidates it and raises `snp_flush_out` if the line was Modified. It never raises `snp_shared_out`.
- R10: A snoop whose tag does not match the stored tag, or whose command is code 3, changes no state and drives neither snoop output.
- R11: A snoop takes priority over a processor request to the same line. `cpu_req_ready` is low in any cycle where a snoop addresses the same index as the presented request, and whenever the controller is busy. The request is then accepted later and sees the post-snoop state.
- R12: If the victim loses its Modified state to a snoop while its write-back waits for grant, the write-back request is withdrawn and the fill request follows without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor access presented |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Line address of the access (low IDX_W bits index the array) |
| cpu_req_ready | output | 1 | Access accepted on this edge when valid |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_resp_hit | output | 1 | Access was a hit (valid with cpu_resp_valid) |
| bus_req_valid | output | 1 | Bus request pending |
| bus_req_cmd | output | 2 | 1 read, 2 read-for-ownership, 3 write-back |
| bus_req_addr | output | ADDR_W | Line address of the request |
| bus_grant | input | 1 | Request performed on this edge |
| bus_shared_in | input | 1 | Wired-OR shared line from other caches, sampled at grant |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Command of the snooped transaction (same codes) |
| snp_addr | input | ADDR_W | Line address of the snooped transaction |
| snp_shared_out | output | 1 | This cache holds a copy (combinational) |
| snp_flush_out | output | 1 | This cache supplies dirty data (combinational) |

## Verification
Snoop answers are combinational, so the bench compares them with its own line-state model one time unit after driving the snoop, before the edge that applies the state change. A local hit responds in the cycle after acceptance, and a bus-served access responds in the cycle after the grant edge. The bench therefore samples response and request ports at the falling edge that follows each such edge, and it holds grants back for an extra cycle where it needs to see a request held. Line states that have no port of their own are read back through later behaviour: a silent or bus-visible write, a hit or a miss, and the snoop outputs.

// File: rtl/coh_mesi_pkg.sv
`timescale 1ns/1ps
package coh_mesi_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} line_st_t;
  typedef enum logic [1:0] {CMD_NONE = 2'd0, CMD_RD = 2'd1, CMD_RDX = 2'd2, CMD_WB = 2'd3} bus_cmd_t;
  typedef enum logic [2:0] {F_IDLE, F_RESP, F_WB, F_FILL, F_UPG} ctl_st_t;
endpackage

// File: rtl/coh_line_store.sv
`timescale 1ns/1ps
module coh_line_store
  import coh_mesi_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] ra_idx,
  output logic [TAG_W-1:0] ra_tag,
  output line_st_t         ra_st,
  input  logic [IDX_W-1:0] rb_idx,
  output logic [TAG_W-1:0] rb_tag,
  output line_st_t         rb_st,
  input  logic             wa_en,
  input  logic [IDX_W-1:0] wa_idx,
  input  logic [TAG_W-1:0] wa_tag,
  input  line_st_t         wa_st,
  input  logic             wb_en,
  input  logic [IDX_W-1:0] wb_idx,
  input  line_st_t         wb_st
);
  localparam int LINES = 1 << IDX_W;

  line_st_t         st_vec  [LINES];
  logic [TAG_W-1:0] tag_vec [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    line_st_t         st_q, st_d;
    logic             st_en;
    logic [TAG_W-1:0] tag_q;

    // Processor-side write first, snoop-side write overrides it.
    always_comb begin
      st_en = 1'b0;
      st_d  = st_q;
      if (wa_en && wa_idx == IDX_W'(g)) begin
        st_en = 1'b1;
        st_d  = wa_st;
      end
      if (wb_en && wb_idx == IDX_W'(g)) begin
        st_en = 1'b1;
        st_d  = wb_st;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     st_q <= ST_I;
      else if (st_en) st_q <= st_d;
    end

    always_ff @(posedge clk) begin
      if (wa_en && wa_idx == IDX_W'(g)) tag_q <= wa_tag;
    end

    assign st_vec[g]  = st_q;
    assign tag_vec[g] = tag_q;
  end

  assign ra_st  = st_vec[ra_idx];
  assign ra_tag = tag_vec[ra_idx];
  assign rb_st  = st_vec[rb_idx];
  assign rb_tag = tag_vec[rb_idx];
endmodule

// File: rtl/coh_snoop_unit.sv
`timescale 1ns/1ps
module coh_snoop_unit
  import coh_mesi_pkg::*;
#(
  parameter int TAG_W = 13
) (
  input  logic             snp_valid,
  input  bus_cmd_t         snp_cmd,
  input  logic [TAG_W-1:0] snp_tag,
  input  logic [TAG_W-1:0] line_tag,
  input  line_st_t         line_st,
  output logic             shared_out,
  output logic             flush_out,
  output logic             upd_en,
  output line_st_t         upd_st
);
  logic match;

  always_comb begin
    match      = snp_valid && (line_st != ST_I) && (line_tag == snp_tag);
    shared_out = 1'b0;
    flush_out  = 1'b0;
    upd_en     = 1'b0;
    upd_st     = line_st;
    if (match) begin
      case (snp_cmd)
        CMD_RD: begin
          shared_out = 1'b1;
          flush_out  = (line_st == ST_M);
          upd_en     = (line_st != ST_S);
          upd_st     = ST_S;
        end
        CMD_RDX: begin
          flush_out = (line_st == ST_M);
          upd_en    = 1'b1;
          upd_st    = ST_I;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/coh_mesi_ctrl.sv
`timescale 1ns/1ps
module coh_mesi_ctrl
  import coh_mesi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  output logic              cpu_req_ready,
  output logic              cpu_resp_valid,
  output logic              cpu_resp_hit,
  output logic              bus_req_valid,
  output logic [1:0]        bus_req_cmd,
  output logic [ADDR_W-1:0] bus_req_addr,
  input  logic              bus_grant,
  input  logic              bus_shared_in,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared_out,
  output logic              snp_flush_out
);
  localparam int TAG_W = ADDR_W - IDX_W;

  ctl_st_t           fsm_q, fsm_d;
  logic              wr_q, hit_q;
  logic [ADDR_W-1:0] addr_q;
  logic              accept;

  logic [IDX_W-1:0]  lk_idx, snp_idx;
  logic [TAG_W-1:0]  lk_tag, ln_tag, sn_tag;
  line_st_t          ln_st, sn_st;
  logic              lk_hit;

  logic              wa_en;
  line_st_t          wa_st;
  logic              upd_en;
  line_st_t          upd_st;
  bus_cmd_t          cmd_d;

  assign snp_idx = snp_addr[IDX_W-1:0];
  assign lk_idx  = (fsm_q == F_IDLE) ? cpu_req_addr[IDX_W-1:0] : addr_q[IDX_W-1:0];
  assign lk_tag  = (fsm_q == F_IDLE) ? cpu_req_addr[ADDR_W-1:IDX_W] : addr_q[ADDR_W-1:IDX_W];
  assign lk_hit  = (ln_st != ST_I) && (ln_tag == lk_tag);

  // A snoop to the same index blocks acceptance for that cycle.
  assign cpu_req_ready = (fsm_q == F_IDLE) &&
                         !(snp_valid && snp_idx == cpu_req_addr[IDX_W-1:0]);
  assign accept        = cpu_req_valid && cpu_req_ready;

  coh_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .ra_idx (lk_idx),
    .ra_tag (ln_tag),
    .ra_st  (ln_st),
    .rb_idx (snp_idx),
    .rb_tag (sn_tag),
    .rb_st  (sn_st),
    .wa_en  (wa_en),
    .wa_idx (lk_idx),
    .wa_tag (lk_tag),
    .wa_st  (wa_st),
    .wb_en  (upd_en),
    .wb_idx (snp_idx),
    .wb_st  (upd_st)
  );

  coh_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
    .snp_valid  (snp_valid),
    .snp_cmd    (bus_cmd_t'(snp_cmd)),
    .snp_tag    (snp_addr[ADDR_W-1:IDX_W]),
    .line_tag   (sn_tag),
    .line_st    (sn_st),
    .shared_out (snp_shared_out),
    .flush_out  (snp_flush_out),
    .upd_en     (upd_en),
    .upd_st     (upd_st)
  );

  // Next-state and request logic
  always_comb begin
    fsm_d         = fsm_q;
    wa_en         = 1'b0;
    wa_st         = ST_I;
    bus_req_valid = 1'b0;
    cmd_d         = CMD_NONE;
    bus_req_addr  = addr_q;
    case (fsm_q)
      F_IDLE: begin
        if (accept) begin
          if (lk_hit) begin
            if (!cpu_req_write) begin
              fsm_d = F_RESP;
            end else if (ln_st == ST_S) begin
              fsm_d = F_UPG;
            end else begin
              wa_en = 1'b1;
              wa_st = ST_M;
              fsm_d = F_RESP;
            end
          end else if (ln_st == ST_M) begin
            fsm_d = F_WB;
          end else begin
            fsm_d = F_FILL;
          end
        end
      end
      F_RESP: fsm_d = F_IDLE;
      F_WB: begin
        if (ln_st == ST_M) begin
          bus_req_valid = 1'b1;
          cmd_d         = CMD_WB;
          bus_req_addr  = {ln_tag, lk_idx};
          if (bus_grant) begin
            wa_en = 1'b1;
            wa_st = ST_I;
            fsm_d = F_FILL;
          end
        end else begin
          fsm_d = F_FILL;
        end
      end
      F_FILL: begin
        bus_req_valid = 1'b1;
        cmd_d         = wr_q ? CMD_RDX : CMD_RD;
        if (bus_grant) begin
          wa_en = 1'b1;
          wa_st = wr_q ? ST_M : (bus_shared_in ? ST_S : ST_E);
          fsm_d = F_RESP;
        end
      end
      F_UPG: begin
        bus_req_valid = 1'b1;
        cmd_d         = CMD_RDX;
        if (bus_grant) begin
          wa_en = 1'b1;
          wa_st = ST_M;
          fsm_d = F_RESP;
        end
      end
      default: fsm_d = F_IDLE;
    endcase
  end

  assign bus_req_cmd    = cmd_d;
  assign cpu_resp_valid = (fsm_q == F_RESP);
  assign cpu_resp_hit   = hit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fsm_q <= F_IDLE;
    else        fsm_q <= fsm_d;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      wr_q   <= cpu_req_write;
      addr_q <= cpu_req_addr;
      hit_q  <= lk_hit;
    end
  end
endmodule

// File: rtl/coh_mesi_chk.sv
`timescale 1ns/1ps
module coh_mesi_chk #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_valid,
  input logic [ADDR_W-1:0] cpu_req_addr,
  input logic              cpu_req_ready,
  input logic              cpu_resp_valid,
  input logic              bus_req_valid,
  input logic [1:0]        bus_req_cmd,
  input logic [ADDR_W-1:0] bus_req_addr,
  input logic              bus_grant,
  input logic              snp_valid,
  input logic [1:0]        snp_cmd,
  input logic [ADDR_W-1:0] snp_addr,
  input logic              snp_shared_out,
  input logic              snp_flush_out
);
  assert_idle_no_request_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_ready |-> !bus_req_valid);

  assert_resp_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_resp_valid |=> !cpu_resp_valid);

  assert_resp_after_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_grant && bus_req_valid && bus_req_cmd != 2'd3) |=> cpu_resp_valid);

  assert_request_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && !bus_grant && !snp_valid) |=>
      (bus_req_valid && $stable(bus_req_cmd) && $stable(bus_req_addr)));

  assert_flush_needs_snoop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush_out |-> snp_valid);

  assert_rdx_not_shared_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_cmd == 2'd2) |-> !snp_shared_out);

  assert_wb_snoop_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_cmd == 2'd3) |-> (!snp_shared_out && !snp_flush_out));

  assert_snoop_blocks_cpu_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && cpu_req_valid && snp_addr[IDX_W-1:0] == cpu_req_addr[IDX_W-1:0])
      |-> !cpu_req_ready);
endmodule

bind coh_mesi_ctrl coh_mesi_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cpu_req_valid  (cpu_req_valid),
  .cpu_req_addr   (cpu_req_addr),
  .cpu_req_ready  (cpu_req_ready),
  .cpu_resp_valid (cpu_resp_valid),
  .bus_req_valid  (bus_req_valid),
  .bus_req_cmd    (bus_req_cmd),
  .bus_req_addr   (bus_req_addr),
  .bus_grant      (bus_grant),
  .snp_valid      (snp_valid),
  .snp_cmd        (snp_cmd),
  .snp_addr       (snp_addr),
  .snp_shared_out (snp_shared_out),
  .snp_flush_out  (snp_flush_out)
);

// File: tb/sim_coh_mesi_ctrl.sv
`timescale 1ns/1ps
module sim_coh_mesi_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_req_valid, cpu_req_write;
  logic [15:0] cpu_req_addr;
  logic        cpu_req_ready, cpu_resp_valid, cpu_resp_hit;
  logic        bus_req_valid;
  logic [1:0]  bus_req_cmd;
  logic [15:0] bus_req_addr;
  logic        bus_grant, bus_shared_in;
  logic        snp_valid;
  logic [1:0]  snp_cmd;
  logic [15:0] snp_addr;
  logic        snp_shared_out, snp_flush_out;

  int checks = 0;
  int fails  = 0;

  // Behavioural line model: 0 Invalid, 1 Shared, 2 Exclusive, 3 Modified
  int          m_st  [8];
  logic [12:0] m_tag [8];

  always #2.5 clk = ~clk;

  coh_mesi_ctrl #(.ADDR_W(16), .IDX_W(3)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_req_ready(cpu_req_ready), .cpu_resp_valid(cpu_resp_valid), .cpu_resp_hit(cpu_resp_hit),
    .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd), .bus_req_addr(bus_req_addr),
    .bus_grant(bus_grant), .bus_shared_in(bus_shared_in),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_shared_out(snp_shared_out), .snp_flush_out(snp_flush_out)
  );

  task automatic chk(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_req(input string rq, input int cmd, input int a);
    chk(rq, "bus_req_valid", bus_req_valid, 1);
    chk(rq, "bus_req_cmd", bus_req_cmd, cmd);
    chk(rq, "bus_req_addr", bus_req_addr, a);
  endtask

  task automatic grant(input bit shr);
    bus_grant = 1'b1;
    bus_shared_in = shr;
    step();
    bus_grant = 1'b0;
    bus_shared_in = 1'b0;
    #1;
  endtask

  task automatic do_snoop(input int cmd, input logic [15:0] a, input string rq);
    int ix;
    bit match;
    ix = int'(a[2:0]);
    match = (m_st[ix] != 0) && (m_tag[ix] == a[15:3]);
    snp_valid = 1'b1;
    snp_cmd = 2'(cmd);
    snp_addr = a;
    #1;
    chk(rq, "snp_shared_out", snp_shared_out, (match && cmd == 1) ? 1 : 0);
    chk(rq, "snp_flush_out", snp_flush_out, (match && cmd != 3 && m_st[ix] == 3) ? 1 : 0);
    step();
    snp_valid = 1'b0;
    if (match && cmd == 1) m_st[ix] = 1;
    if (match && cmd == 2) m_st[ix] = 0;
    #1;
  endtask

  task automatic do_access(input bit wr, input logic [15:0] a, input bit shr, input string rq);
    int ix;
    int st;
    bit hit;
    ix = int'(a[2:0]);
    st = m_st[ix];
    hit = (st != 0) && (m_tag[ix] == a[15:3]);
    cpu_req_valid = 1'b1;
    cpu_req_write = wr;
    cpu_req_addr = a;
    #1;
    chk(rq, "cpu_req_ready", cpu_req_ready, 1);
    step();
    cpu_req_valid = 1'b0;
    #1;
    if (hit && (!wr || st != 1)) begin
      chk(rq, "resp_valid local", cpu_resp_valid, 1);
      chk(rq, "resp_hit local", cpu_resp_hit, 1);
      chk(rq, "no bus on local hit", bus_req_valid, 0);
      if (wr) m_st[ix] = 3;
    end else if (hit) begin
      expect_req(rq, 2, a);
      chk(rq, "busy while upgrading", cpu_req_ready, 0);
      step();
      #1;
      expect_req(rq, 2, a);
      grant(1'b0);
      chk(rq, "resp_valid upgrade", cpu_resp_valid, 1);
      chk(rq, "resp_hit upgrade", cpu_resp_hit, 1);
      m_st[ix] = 3;
    end else begin
      if (st == 3) begin
        expect_req(rq, 3, {m_tag[ix], a[2:0]});
        grant(1'b0);
      end
      expect_req(rq, wr ? 2 : 1, a);
      grant(shr);
      chk(rq, "resp_valid miss", cpu_resp_valid, 1);
      chk(rq, "resp_hit miss", cpu_resp_hit, 0);
      m_tag[ix] = a[15:3];
      m_st[ix] = wr ? 3 : (shr ? 1 : 2);
    end
    step();
    #1;
    chk(rq, "response ends", cpu_resp_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog all actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_st[i] = 0;
      m_tag[i] = '0;
    end
    rst_n = 1'b0;
    cpu_req_valid = 1'b0; cpu_req_write = 1'b0; cpu_req_addr = '0;
    bus_grant = 1'b0; bus_shared_in = 1'b0;
    snp_valid = 1'b0; snp_cmd = '0; snp_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1", "ready after reset", cpu_req_ready, 1);
    chk("R1", "no bus request", bus_req_valid, 0);
    chk("R1", "no response", cpu_resp_valid, 0);
    do_snoop(1, 16'h0010, "R1");

    // R3 read miss unshared, R4 write hit E then M, R2 read hit M
    do_access(1'b0, 16'h0011, 1'b0, "R3");
    do_access(1'b1, 16'h0011, 1'b0, "R4");
    do_access(1'b1, 16'h0011, 1'b0, "R4");
    do_access(1'b0, 16'h0011, 1'b0, "R2");

    // R8 snoop read on M, R2 read hit S, R5 upgrade
    do_snoop(1, 16'h0011, "R8");
    do_access(1'b0, 16'h0011, 1'b0, "R2");
    do_access(1'b1, 16'h0011, 1'b0, "R5");

    // R9 snoop read-for-ownership on M, R3 shared fill, R8 on S
    do_snoop(2, 16'h0011, "R9");
    do_access(1'b0, 16'h0011, 1'b1, "R3");
    do_snoop(1, 16'h0011, "R8");
    do_snoop(2, 16'h0011, "R9");

    // R6 write miss, R7 dirty eviction then silent eviction
    do_access(1'b1, 16'h0022, 1'b0, "R6");
    do_access(1'b0, 16'h00A2, 1'b0, "R7");
    do_access(1'b0, 16'h0122, 1'b1, "R7");

    // R10 tag mismatch and write-back command ignored
    do_snoop(1, 16'h0032, "R10");
    do_snoop(3, 16'h0122, "R10");
    do_access(1'b0, 16'h0122, 1'b0, "R10");

    // R8 E moves to S (visible through the upgrade that follows)
    do_access(1'b0, 16'h0013, 1'b0, "R3");
    do_snoop(1, 16'h0013, "R8");
    do_access(1'b1, 16'h0013, 1'b0, "R8");

    // R11 snoop wins over a processor request to the same index
    do_access(1'b0, 16'h0014, 1'b0, "R11");
    cpu_req_valid = 1'b1; cpu_req_write = 1'b0; cpu_req_addr = 16'h0014;
    snp_valid = 1'b1; snp_cmd = 2'd2; snp_addr = 16'h0014;
    #1;
    chk("R11", "ready blocked by snoop", cpu_req_ready, 0);
    chk("R11", "snoop sees E copy unflushed", snp_flush_out, 0);
    step();
    snp_valid = 1'b0;
    m_st[4] = 0;
    #1;
    chk("R11", "ready after snoop", cpu_req_ready, 1);
    step();
    cpu_req_valid = 1'b0;
    #1;
    expect_req("R11", 1, 16'h0014);
    grant(1'b0);
    chk("R11", "resp_valid", cpu_resp_valid, 1);
    chk("R11", "miss after snoop", cpu_resp_hit, 0);
    m_st[4] = 2; m_tag[4] = 13'h0002;
    step();
    #1;

    // R12 victim invalidated while its write-back waits
    do_access(1'b1, 16'h0015, 1'b0, "R12");
    cpu_req_valid = 1'b1; cpu_req_write = 1'b0; cpu_req_addr = 16'h0035;
    #1;
    step();
    cpu_req_valid = 1'b0;
    #1;
    expect_req("R12", 3, 16'h0015);
    snp_valid = 1'b1; snp_cmd = 2'd2; snp_addr = 16'h0015;
    #1;
    chk("R12", "victim flushed by snoop", snp_flush_out, 1);
    step();
    snp_valid = 1'b0;
    #1;
    chk("R12", "write-back withdrawn", bus_req_valid, 0);
    step();
    #1;
    expect_req("R12", 1, 16'h0035);
    grant(1'b1);
    chk("R12", "resp_valid", cpu_resp_valid, 1);
    chk("R12", "resp_hit", cpu_resp_hit, 0);
    m_st[5] = 1; m_tag[5] = 13'h0006;
    step();
    #1;
    do_snoop(1, 16'h0035, "R12");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule